// File: doc/BRIEF.md
# I2C Serial Clock Period Generator

This block produces the serial clock waveform for an I2C controller from one packed 32-bit timing word. The clock is divided in two stages. A power-of-two prescaler makes a one-cycle tick every 2^B system clocks. Two phase counters then hold the line released for H+1 ticks and pulled low for L+1 ticks. Each stored count is one less than the number of ticks it stands for.

The controller that owns the bus reads the line level and two one-cycle strobes. One strobe marks the first cycle of each low phase and the other marks the first cycle of each high phase that follows a low phase. An open-drain pull-down enable is the complement of the level. A timing word takes effect only at a period boundary. Clearing the enable releases the line and restarts the sequence at the start of a high phase.

A parameter selects a narrower variant whose phase fields are three bits wide instead of four.

Top module: `scl_period_gen`

## Requirements
- R1: After the enable rises, the line stays high for (H+1)·2^B system clocks and then low for (L+1)·2^B system clocks. This pattern repeats while the enable stays set.
- R2: The prescaler exponent B is timing bits [3:0], with a value range of 0 to 15.
- R3: The high count H is read LSB-aligned from bit 16 and the low count L from bit 12. Each is PHASE_W bits wide: bits [19:16] and [15:12] when PHASE_W=4, and bits [18:16] and [14:12] when PHASE_W=3.
- R4: With both fields at their maximum, one period spans 32 prescaler ticks when PHASE_W=4 and 16 ticks when PHASE_W=3.
- R5: Timing bits [31:20] and [11:4] have no effect on the waveform.
- R6: A timing word that changes during a period leaves the rest of that period unchanged. The value present at the period's final clock edge governs the next period.
- R7: In the cycle after the enable is sampled low, the level is high, both strobes are low and the pull-down is off. When the enable is raised again, a full high phase is produced with the timing word applied while the block was disabled.
- R8: fall_stb is high for exactly the first cycle of each low phase. rise_stb is high for exactly the first cycle of each high phase that follows a low phase. The two strobes are never high together.
- R9: scl_drive_low is high exactly when scl_level is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the generator; low releases the line and restarts |
| timing_word | input | 32 | Packed timing value: B [3:0], L at bit 12, H at bit 16 |
| scl_level | output | 1 | Current serial clock level (1 = released) |
| scl_drive_low | output | 1 | Open-drain pull-down enable |
| rise_stb | output | 1 | One-cycle mark of a low-to-high boundary |
| fall_stb | output | 1 | One-cycle mark of a high-to-low boundary |

## Verification
The assertions assume a released line only one cycle after the enable is sampled low. They also assume that every level change while the enable is held is a phase boundary and carries exactly one strobe. Both assumptions hold only if the enable is a clean synchronous signal and the timing word is registered in the system clock domain. The bench meets this by driving both on the falling edge.

Random timing words keep B between 0 and 3 so that periods stay short, while the upper and middle bits are left random. Directed cases cover the zero and maximum fields, the narrow variant, a change in the middle of a period, and disabling during a low phase.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
    // Field positions inside the timing word
    localparam int BASE_LSB = 0;
    localparam int LO_LSB   = 12;
    localparam int HI_LSB   = 16;

    typedef enum logic {
        PH_HIGH = 1'b0,
        PH_LOW  = 1'b1
    } scl_phase_e;
endpackage

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
    parameter int EXP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [EXP_W-1:0] exp_i,
    output logic             tick_o
);
    localparam int CNT_W = (1 << EXP_W) - 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } pre_s;

    pre_s             st_d, st_q;
    logic [CNT_W-1:0] limit;

    always_comb begin
        for (int i = 0; i < CNT_W; i++) begin
            limit[i] = (i < int'(exp_i));
        end
        tick_o = run && (st_q.cnt == limit);
        st_d   = st_q;
        if (!run || tick_o) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq
    import scl_gen_pkg::*;
#(
    parameter int PHASE_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               tick,
    input  logic [PHASE_W-1:0] hi_len,
    input  logic [PHASE_W-1:0] lo_len,
    output logic               level_o,
    output logic               rise_o,
    output logic               fall_o,
    output logic               wrap_o
);
    typedef struct packed {
        scl_phase_e         ph;
        logic [PHASE_W-1:0] cnt;
        logic               rise;
        logic               fall;
    } seq_s;

    seq_s st_d, st_q;
    logic end_hi;

    always_comb begin
        end_hi = run && tick && (st_q.ph == PH_HIGH) && (st_q.cnt == hi_len);
        wrap_o = run && tick && (st_q.ph == PH_LOW) && (st_q.cnt == lo_len);

        st_d      = st_q;
        st_d.rise = 1'b0;
        st_d.fall = 1'b0;
        if (!run) begin
            st_d.ph  = PH_HIGH;
            st_d.cnt = '0;
        end else if (end_hi) begin
            st_d.ph   = PH_LOW;
            st_d.cnt  = '0;
            st_d.fall = 1'b1;
        end else if (wrap_o) begin
            st_d.ph   = PH_HIGH;
            st_d.cnt  = '0;
            st_d.rise = 1'b1;
        end else if (tick) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end

        level_o = (st_q.ph == PH_HIGH);
        rise_o  = st_q.rise;
        fall_o  = st_q.fall;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_HIGH, cnt: '0, rise: 1'b0, fall: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/scl_period_gen.sv
module scl_period_gen
    import scl_gen_pkg::*;
#(
    parameter int PHASE_W = 4,
    parameter int EXP_W   = 4,
    parameter int WORD_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [WORD_W-1:0] timing_word,
    output logic              scl_level,
    output logic              scl_drive_low,
    output logic              rise_stb,
    output logic              fall_stb
);
    typedef struct packed {
        logic [EXP_W-1:0]   base;
        logic [PHASE_W-1:0] hi;
        logic [PHASE_W-1:0] lo;
    } cfg_s;

    cfg_s cfg_d, cfg_q, cfg_new;
    logic tick;
    logic wrap;

    always_comb begin
        cfg_new.base = timing_word[BASE_LSB +: EXP_W];
        cfg_new.hi   = timing_word[HI_LSB +: PHASE_W];
        cfg_new.lo   = timing_word[LO_LSB +: PHASE_W];
        // Load only while idle or on the last edge of a period
        cfg_d = (!enable || wrap) ? cfg_new : cfg_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    scl_prescaler #(.EXP_W(EXP_W)) i_prescaler (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (enable),
        .exp_i  (cfg_q.base),
        .tick_o (tick)
    );

    scl_phase_seq #(.PHASE_W(PHASE_W)) i_phase_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (enable),
        .tick    (tick),
        .hi_len  (cfg_q.hi),
        .lo_len  (cfg_q.lo),
        .level_o (scl_level),
        .rise_o  (rise_stb),
        .fall_o  (fall_stb),
        .wrap_o  (wrap)
    );

    assign scl_drive_low = ~scl_level;
endmodule

// File: rtl/scl_period_chk.sv
module scl_period_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic scl_level,
    input logic rise_stb,
    input logic fall_stb
);
    // R7
    release_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (scl_level && !rise_stb && !fall_stb));

    // R8
    strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rise_stb, fall_stb}));

    // R8
    fall_marks_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_stb |-> (!scl_level && $past(scl_level)));

    // R8
    rise_marks_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_stb |-> (scl_level && !$past(scl_level)));

    // R8
    edge_has_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && $past(enable) && (scl_level != $past(scl_level)))
            |-> (rise_stb || fall_stb));
endmodule

bind scl_period_gen scl_period_chk i_scl_period_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .scl_level (scl_level),
    .rise_stb  (rise_stb),
    .fall_stb  (fall_stb)
);

// File: tb/test_scl_period_gen.sv
module test_scl_period_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  en = 2'b00;
    logic [31:0] tw [2];
    logic [1:0]  lvl, drv, rs, fs;
    int          checks = 0;
    int          fails = 0;

    always #10 clk = ~clk;

    scl_period_gen i_scl_period_gen (
        .clk(clk), .rst_n(rst_n), .enable(en[0]), .timing_word(tw[0]),
        .scl_level(lvl[0]), .scl_drive_low(drv[0]),
        .rise_stb(rs[0]), .fall_stb(fs[0])
    );

    scl_period_gen #(.PHASE_W(3)) i_scl_period_gen_narrow (
        .clk(clk), .rst_n(rst_n), .enable(en[1]), .timing_word(tw[1]),
        .scl_level(lvl[1]), .scl_drive_low(drv[1]),
        .rise_stb(rs[1]), .fall_stb(fs[1])
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_hi(int w, logic [31:0] t);
        int m = (w == 1) ? 7 : 15;
        return ((int'(t[19:16]) & m) + 1) << t[3:0];
    endfunction

    function automatic int exp_lo(int w, logic [31:0] t);
        int m = (w == 1) ? 7 : 15;
        return ((int'(t[15:12]) & m) + 1) << t[3:0];
    endfunction

    // Count falling-edge samples while the level equals want
    task automatic count_phase(int w, bit want, output int n);
        int bad = 0;
        n = 0;
        while (lvl[w] == want && n < 100000) begin
            if (drv[w] == lvl[w]) bad++;
            n++;
            @(negedge clk);
        end
        chk("R9 drive_low complement", bad, 0);
    endtask

    task automatic period(int w, int ehi, int elo, string tag);
        int n;
        count_phase(w, 1'b1, n);
        chk({"R1 high length ", tag}, n, ehi);
        chk({"R8 fall strobe ", tag}, int'(fs[w]), 1);
        count_phase(w, 1'b0, n);
        chk({"R1 low length ", tag}, n, elo);
        chk({"R8 rise strobe ", tag}, int'(rs[w]), 1);
    endtask

    task automatic start(int w, logic [31:0] t);
        @(negedge clk);
        en[w] = 1'b0;
        tw[w] = t;
        @(negedge clk);
        @(negedge clk);
        en[w] = 1'b1;
    endtask

    task automatic stop(int w);
        @(negedge clk);
        en[w] = 1'b0;
        @(negedge clk);
    endtask

    task automatic full_check(int w, logic [31:0] t, string tag);
        start(w, t);
        period(w, exp_hi(w, t), exp_lo(w, t), tag);
        period(w, exp_hi(w, t), exp_lo(w, t), tag);
        stop(w);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int n;
        logic [31:0] a, b;
        void'($urandom(32'd4711));
        tw[0] = '0;
        tw[1] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R7 reset level", int'(lvl[0]), 1);
        chk("R9 reset drive", int'(drv[0]), 0);
        chk("R8 reset strobes", int'(rs[0] | fs[0]), 0);

        // R1 R2 R3 directed
        full_check(0, 32'h0000_0000, "zero fields");
        full_check(0, 32'h0003_5002, "B2 H3 L5");
        // R4 maximum fields
        full_check(0, 32'h000F_F000, "R4 wide max");
        full_check(1, 32'h000F_F000, "R4 narrow max");
        // R3 narrow field positions
        full_check(1, 32'h000A_5001, "R3 narrow fields");
        // R5 upper and middle bits ignored
        full_check(0, 32'hFFF3_5FF1, "R5 junk bits");

        // R6 mid-period change
        a = 32'h0005_2001;
        b = 32'h0001_3000;
        start(0, a);
        @(negedge clk);
        tw[0] = b;
        period(0, exp_hi(0, a) - 1, exp_lo(0, a), "R6 current period");
        period(0, exp_hi(0, b), exp_lo(0, b), "R6 next period");
        stop(0);

        // R7 disable during low phase
        start(0, 32'h0002_4001);
        count_phase(0, 1'b1, n);
        @(negedge clk);
        en[0] = 1'b0;
        tw[0] = 32'h0001_1000;
        @(negedge clk);
        chk("R7 released level", int'(lvl[0]), 1);
        chk("R7 drive off", int'(drv[0]), 0);
        chk("R7 strobes quiet", int'(rs[0] | fs[0]), 0);
        @(negedge clk);
        en[0] = 1'b1;
        period(0, 2, 2, "R7 restart");
        stop(0);

        // Random mix on both widths
        for (int i = 0; i < 24; i++) begin
            logic [31:0] t = $urandom;
            t[3:0] = 4'($urandom % 4);
            full_check(i % 2, t, "random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule